// File: doc/BRIEF.md
# Packet Transfer Status and Interrupt Controller

This block keeps the control and status state of a packet mover that shifts data between a FIFO and a peripheral bus. Software programs three things through a small register port: the enables, a packet length, and a restart. A restart starts a packet. The block then adds up the bytes reported by each accepted transfer beat. The packet ends normally when the running total reaches the programmed length. It ends abnormally, at once, if the FIFO reports an error while the packet is in flight.

Each kind of termination sets a sticky flag in the status register. Each flag can raise the single CPU interrupt line when its own enable bit is set. The flags are cleared in three ways: by writing 1 to them, by a level-sensitive clear bit in the control register, or by dropping master enable. A restart also clears them, so every packet begins with clean status. The `xfer_active` output tells the data mover that a packet is in progress. No enable bit affects it.

Top module: `pkt_xfer_stat`

Register map (word address on `wr_addr` / `rd_addr`): 0 = control, 1 = packet size, 2 = status, 3 = reads 0. Writes are byte-masked by `wr_be`. Lane 3 holds bits 31:24.

## Requirements
- R1: After reset, the control, packet-size and status registers read 0, `irq` is 0 and `xfer_active` is 0.
- R2: The control register (address 0) holds master enable at bit 0, normal-interrupt enable at bit 8, abort-interrupt enable at bit 9 and status-clear at bit 16. All other bits read 0, and address 3 reads 0.
- R3: Writing 8'h01 into lane 3 of address 1 while master enable is 1 restarts the engine. After the restart, the count is 0, both flags are 0 and `xfer_active` is 1. With master enable at 0, the same write only stores the size and does not start a packet.
- R4: While a packet is active, each accepted beat adds `beat_bytes` to the count. When the sum reaches or exceeds the size, the normal flag sets, `xfer_active` drops and the count holds the final sum.
- R5: A FIFO error while a packet is active sets the abort flag and ends the packet, whatever the abort-interrupt enable is. A beat in the same cycle is not counted, and the error takes priority over completion. The abort flag sets only in this case.
- R6: `irq` is 1 when (abort flag and abort enable) or (normal flag and normal enable), with master enable at 1. It follows the flags in the same cycle.
- R7: Writing address 2 with bit 28 set clears the abort flag, and with bit 24 set clears the normal flag. A flag event in the same cycle wins over the clear.
- R8: While status-clear is 1 or master enable is 0, both flags are held at 0 and `irq` is 0. Both flags clear on the same edge that writes these control bits.
- R9: The status register reads the abort flag at bit 28, the normal flag at bit 24 and the byte count at bits 23:0, with the other bits 0. The packet-size register reads its 24-bit size at bits 23:0 and 0 above that.
- R10: Beats arriving while no packet is active leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write word address |
| wr_data | input | 32 | Register write data |
| wr_be | input | 4 | Write byte enables, lane 3 = bits 31:24 |
| rd_addr | input | 2 | Register read word address |
| rd_data | output | 32 | Register read data (combinational) |
| beat_valid | input | 1 | An accepted transfer beat this cycle |
| beat_bytes | input | BEAT_W | Bytes moved by the beat |
| fifo_err | input | 1 | FIFO error report |
| xfer_active | output | 1 | Packet in progress |
| irq | output | 1 | CPU interrupt |

## Verification
A count that drifts shows up in the status read-back one cycle after the beat that caused it. A stale or wrongly set flag changes `irq` in the cycle right after the triggering beat, error or register write. Because of this, the bench reads status and samples `irq` at the first negative edge after each event. The overlap cases are forced directly: an error arriving with the completing beat, an error arriving with a write-1-to-clear, and a restart arriving over a set flag. In each case a wrong priority changes the value read back within one cycle.

// File: rtl/pkt_xfer_stat.sv
module pkt_xfer_stat #(
  parameter int CNT_W  = 24,
  parameter int BEAT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [3:0]        wr_be,
  input  logic [1:0]        rd_addr,
  output logic [31:0]       rd_data,
  input  logic              beat_valid,
  input  logic [BEAT_W-1:0] beat_bytes,
  input  logic              fifo_err,
  output logic              xfer_active,
  output logic              irq
);
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_SIZE = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;
  localparam int B_ME  = 0;
  localparam int B_NIE = 8;
  localparam int B_AIE = 9;
  localparam int B_RC  = 16;
  localparam int B_ABT = 28;
  localparam int B_NRM = 24;
  localparam int SUM_W = CNT_W + 1;
  localparam int SIZE_LANES = (CNT_W + 7) / 8;

  logic me_q, nie_q, aie_q, rc_q;
  logic [CNT_W-1:0] size_q, cnt_q;
  logic active_q, abort_q, norm_q;

  logic wr_ctrl, wr_size, wr_stat, restart;
  logic me_nxt, rc_nxt, hold_clr;
  logic abort_evt, done_evt;
  logic [SUM_W-1:0] cnt_sum;

  assign wr_ctrl  = wr_en && (wr_addr == A_CTRL);
  assign wr_size  = wr_en && (wr_addr == A_SIZE);
  assign wr_stat  = wr_en && (wr_addr == A_STAT);
  assign restart  = wr_size && wr_be[3] && (wr_data[31:24] == 8'h01) && me_q;
  assign me_nxt   = (wr_ctrl && wr_be[0]) ? wr_data[B_ME] : me_q;
  assign rc_nxt   = (wr_ctrl && wr_be[2]) ? wr_data[B_RC] : rc_q;
  assign hold_clr = !me_nxt || rc_nxt;

  assign cnt_sum   = {1'b0, cnt_q} + {{(SUM_W-BEAT_W){1'b0}}, beat_bytes};
  assign abort_evt = active_q && fifo_err;
  assign done_evt  = active_q && beat_valid && !fifo_err && (cnt_sum >= {1'b0, size_q});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      me_q  <= 1'b0;
      nie_q <= 1'b0;
      aie_q <= 1'b0;
      rc_q  <= 1'b0;
    end else begin
      me_q <= me_nxt;
      rc_q <= rc_nxt;
      if (wr_ctrl && wr_be[1]) begin
        nie_q <= wr_data[B_NIE];
        aie_q <= wr_data[B_AIE];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q <= '0;
    end else if (wr_size) begin
      for (int b = 0; b < SIZE_LANES; b++) begin
        if (wr_be[b]) begin
          for (int k = 0; k < 8; k++) begin
            if (b*8 + k < CNT_W) size_q[b*8 + k] <= wr_data[b*8 + k];
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (restart) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else begin
      if (abort_evt || done_evt) active_q <= 1'b0;
      if (active_q && beat_valid && !fifo_err) cnt_q <= cnt_sum[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      abort_q <= 1'b0;
      norm_q  <= 1'b0;
    end else if (hold_clr || restart) begin
      abort_q <= 1'b0;
      norm_q  <= 1'b0;
    end else begin
      if (abort_evt) abort_q <= 1'b1;
      else if (wr_stat && wr_be[3] && wr_data[B_ABT]) abort_q <= 1'b0;
      if (done_evt) norm_q <= 1'b1;
      else if (wr_stat && wr_be[3] && wr_data[B_NRM]) norm_q <= 1'b0;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL: begin
        rd_data[B_ME]  = me_q;
        rd_data[B_NIE] = nie_q;
        rd_data[B_AIE] = aie_q;
        rd_data[B_RC]  = rc_q;
      end
      A_SIZE: rd_data[CNT_W-1:0] = size_q;
      A_STAT: begin
        rd_data[CNT_W-1:0] = cnt_q;
        rd_data[B_ABT]     = abort_q;
        rd_data[B_NRM]     = norm_q;
      end
      default: rd_data = '0;
    endcase
  end

  assign xfer_active = active_q;
  assign irq = me_q && ((abort_q && aie_q) || (norm_q && nie_q));
endmodule

// File: rtl/pkt_xfer_stat_chk.sv
module pkt_xfer_stat_chk #(
  parameter int CNT_W  = 24,
  parameter int BEAT_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [1:0]        wr_addr,
  input logic [31:0]       wr_data,
  input logic [3:0]        wr_be,
  input logic              beat_valid,
  input logic [BEAT_W-1:0] beat_bytes,
  input logic              fifo_err,
  input logic              xfer_active,
  input logic              irq,
  input logic              me_q,
  input logic              rc_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  size_q,
  input logic              abort_q,
  input logic              norm_q
);
  logic rst_c;
  logic [CNT_W:0] sum_c;
  assign rst_c = wr_en && (wr_addr == 2'd1) && wr_be[3] && (wr_data[31:24] == 8'h01) && me_q;
  assign sum_c = {1'b0, cnt_q} + {{(CNT_W+1-BEAT_W){1'b0}}, beat_bytes};

  a_r3_restart: assert property (@(posedge clk) disable iff (!rst_n)
    rst_c |=> xfer_active && (cnt_q == '0) && !abort_q && !norm_q);

  a_r3_no_start_me_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_active && !me_q) |=> !xfer_active);

  a_r4_normal_end: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_active && beat_valid && !fifo_err && (sum_c >= {1'b0, size_q}) && me_q && !rc_q && !wr_en)
    |=> norm_q && !xfer_active);

  a_r5_abort_on_err: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_active && fifo_err && me_q && !rc_q && !wr_en) |=> abort_q && !xfer_active);

  a_r5_abort_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(abort_q) |-> $past(xfer_active && fifo_err));

  a_r8_me_low_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !me_q |-> (!abort_q && !norm_q && !irq));

  a_r10_idle_count: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_active && !rst_c) |=> $stable(cnt_q));
endmodule

bind pkt_xfer_stat pkt_xfer_stat_chk #(.CNT_W(CNT_W), .BEAT_W(BEAT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .wr_be(wr_be), .beat_valid(beat_valid), .beat_bytes(beat_bytes), .fifo_err(fifo_err),
  .xfer_active(xfer_active), .irq(irq), .me_q(me_q), .rc_q(rc_q), .cnt_q(cnt_q),
  .size_q(size_q), .abort_q(abort_q), .norm_q(norm_q)
);

// File: tb/tb_pkt_xfer_stat.sv
module tb_pkt_xfer_stat;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0] wr_be = '0;
  logic [1:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic beat_valid = 1'b0;
  logic [2:0] beat_bytes = '0;
  logic fifo_err = 1'b0;
  logic xfer_active, irq;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  pkt_xfer_stat dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_be(wr_be), .rd_addr(rd_addr), .rd_data(rd_data), .beat_valid(beat_valid),
    .beat_bytes(beat_bytes), .fifo_err(fifo_err), .xfer_active(xfer_active), .irq(irq)
  );

  // op: 1 write, 2 read check, 3 beat, 4 fifo error, 5 irq check, 6 active check
  localparam int NV = 46;
  localparam logic [75:0] VEC [0:NV-1] = '{
    {4'd2, 4'd1, 4'd0, 32'h0,        32'h0},        // R1
    {4'd2, 4'd1, 4'd2, 32'h0,        32'h0},        // R1
    {4'd2, 4'd1, 4'd1, 32'h0,        32'h0},        // R1
    {4'd5, 4'd1, 4'd0, 32'h0,        32'h0},        // R1
    {4'd1, 4'd2, 4'd0, 32'hFFFFFFFF, 32'h0},
    {4'd2, 4'd2, 4'd0, 32'h0,        32'h00010301}, // R2
    {4'd2, 4'd2, 4'd3, 32'h0,        32'h0},        // R2
    {4'd1, 4'd2, 4'd0, 32'h00000301, 32'h0},
    {4'd2, 4'd2, 4'd0, 32'h0,        32'h00000301}, // R2
    {4'd1, 4'd3, 4'd1, 32'h0100000A, 32'h0},
    {4'd6, 4'd3, 4'd0, 32'h0,        32'h1},        // R3
    {4'd2, 4'd9, 4'd1, 32'h0,        32'h0000000A}, // R9
    {4'd3, 4'd4, 4'd0, 32'h4,        32'h0},
    {4'd3, 4'd4, 4'd0, 32'h4,        32'h0},
    {4'd2, 4'd4, 4'd2, 32'h0,        32'h00000008}, // R4
    {4'd5, 4'd6, 4'd0, 32'h0,        32'h0},        // R6
    {4'd3, 4'd4, 4'd0, 32'h2,        32'h0},
    {4'd2, 4'd9, 4'd2, 32'h0,        32'h0100000A}, // R9 R4
    {4'd6, 4'd4, 4'd0, 32'h0,        32'h0},        // R4
    {4'd5, 4'd6, 4'd0, 32'h0,        32'h1},        // R6
    {4'd3, 4'd10,4'd0, 32'h4,        32'h0},
    {4'd2, 4'd10,4'd2, 32'h0,        32'h0100000A}, // R10
    {4'd1, 4'd7, 4'd2, 32'h01000000, 32'h0},
    {4'd2, 4'd7, 4'd2, 32'h0,        32'h0000000A}, // R7
    {4'd5, 4'd7, 4'd0, 32'h0,        32'h0},        // R7
    {4'd1, 4'd3, 4'd1, 32'h01000010, 32'h0},
    {4'd3, 4'd4, 4'd0, 32'h3,        32'h0},
    {4'd4, 4'd5, 4'd0, 32'h0,        32'h0},
    {4'd2, 4'd5, 4'd2, 32'h0,        32'h10000003}, // R5
    {4'd5, 4'd6, 4'd0, 32'h0,        32'h1},        // R6
    {4'd1, 4'd6, 4'd0, 32'h00000001, 32'h0},
    {4'd5, 4'd6, 4'd0, 32'h0,        32'h0},        // R6
    {4'd2, 4'd5, 4'd2, 32'h0,        32'h10000003}, // R5
    {4'd1, 4'd8, 4'd0, 32'h00010001, 32'h0},
    {4'd2, 4'd8, 4'd2, 32'h0,        32'h00000003}, // R8
    {4'd1, 4'd8, 4'd0, 32'h00000001, 32'h0},
    {4'd1, 4'd3, 4'd1, 32'h01000008, 32'h0},
    {4'd4, 4'd5, 4'd0, 32'h0,        32'h0},
    {4'd2, 4'd5, 4'd2, 32'h0,        32'h10000000}, // R5
    {4'd1, 4'd8, 4'd0, 32'h00000000, 32'h0},
    {4'd2, 4'd8, 4'd2, 32'h0,        32'h0},        // R8
    {4'd1, 4'd3, 4'd1, 32'h01000004, 32'h0},
    {4'd2, 4'd3, 4'd1, 32'h0,        32'h00000004}, // R3
    {4'd3, 4'd3, 4'd0, 32'h4,        32'h0},
    {4'd2, 4'd3, 4'd2, 32'h0,        32'h0},        // R3
    {4'd6, 4'd3, 4'd0, 32'h0,        32'h0}         // R3
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 1'b0; wr_be = '0; wr_data = '0; wr_addr = '0;
    beat_valid = 1'b0; beat_bytes = '0; fifo_err = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); idle();
    wr_en = 1'b1; wr_addr = a; wr_data = d; wr_be = 4'hF;
  endtask

  task automatic beat(input logic [2:0] n);
    @(negedge clk); idle();
    beat_valid = 1'b1; beat_bytes = n;
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] a, input logic [31:0] exp);
    @(negedge clk); idle();
    rd_addr = a; #1;
    check(tag, rd_data, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk); idle();
      case (VEC[i][75:72])
        4'd1: begin wr_en = 1'b1; wr_addr = VEC[i][65:64]; wr_data = VEC[i][63:32]; wr_be = 4'hF; end
        4'd2: begin rd_addr = VEC[i][65:64]; #1;
                    check($sformatf("R%0d vec %0d", VEC[i][71:68], i), rd_data, VEC[i][31:0]); end
        4'd3: begin beat_valid = 1'b1; beat_bytes = VEC[i][34:32]; end
        4'd4: fifo_err = 1'b1;
        4'd5: begin #1; check($sformatf("R%0d vec %0d irq", VEC[i][71:68], i), {31'b0, irq}, VEC[i][31:0]); end
        default: begin #1; check($sformatf("R%0d vec %0d active", VEC[i][71:68], i), {31'b0, xfer_active}, VEC[i][31:0]); end
      endcase
    end

    // R5: error together with the completing beat -> abort only, beat not counted
    wr(2'd0, 32'h00000301);
    wr(2'd1, 32'h01000004);
    @(negedge clk); idle(); beat_valid = 1'b1; beat_bytes = 3'd4; fifo_err = 1'b1;
    rd_chk("R5 err beats completion", 2'd2, 32'h10000000);

    // R7: set event beats write-1-to-clear in the same cycle
    wr(2'd1, 32'h01000008);
    beat(3'd4);
    @(negedge clk); idle();
    fifo_err = 1'b1; wr_en = 1'b1; wr_addr = 2'd2; wr_be = 4'hF; wr_data = 32'h10000000;
    rd_chk("R7 set wins over clear", 2'd2, 32'h10000004);

    // R3: restart clears a set abort flag
    wr(2'd1, 32'h01000002);
    rd_chk("R3 restart clears flags", 2'd2, 32'h00000000);
    @(negedge clk); #1; check("R3 restart active", {31'b0, xfer_active}, 32'h1);

    // R6: normal enable gates irq; abort enable alone does not pass it
    wr(2'd0, 32'h00000101);
    beat(3'd2);
    @(negedge clk); idle(); #1; check("R6 normal irq", {31'b0, irq}, 32'h1);
    wr(2'd0, 32'h00000201);
    @(negedge clk); idle(); #1; check("R6 normal irq masked", {31'b0, irq}, 32'h0);

    // R1: reset in the middle of a packet
    wr(2'd1, 32'h01000010);
    beat(3'd1);
    @(negedge clk); idle(); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd_chk("R1 ctrl after reset", 2'd0, 32'h0);
    rd_chk("R1 status after reset", 2'd2, 32'h0);
    #1; check("R1 irq after reset", {31'b0, irq}, 32'h0);
    check("R1 active after reset", {31'b0, xfer_active}, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule